// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control machine behind a request to move a device from one lifecycle state to another. After a request in the idle state it walks a strictly ordered chain of steps: clock-source switch, counter increment, counter write, legality check, token hashing, an optional erase handshake, a two-part token comparison and finally the write of the new state. Each step raises a one-cycle start strobe when entered and then waits on its own done or error input. The clock, counter, hashing and non-volatile work happen elsewhere. This block only orders the steps and reacts to their outcome.

Every step that can fail leaves straight for a terminal completion state with a failure flag. Two alarm lines independently push the machine into a sticky alarm state from nearly anywhere. The state register holds one of fifteen sparse codes. Any other value is taken as a fault and leads to a dedicated fault state on the next clock.

Top module: `lseq_fsm`

## Requirements
- R1: The state output is a 7-bit code built from a state index d (1..15): bits [6:3] are d, bit 2 is d1^d2^d3, bit 1 is d0^d2^d3 and bit 0 is d0^d1^d3. The indices are boot=1, idle=2, the nine steps 3..11 (step k has index k+3), post=12, scrap=13, alarm=14 and fault=15. Reset gives boot, with all flags and strobes low.
- R2: Boot moves to idle on the next clock in all cases, with the alarm inputs ignored.
- R3: In idle, with no alarm: scrap_mode_i moves to scrap, taking priority over xfer_req_i. Otherwise xfer_req_i moves to step 0. With neither, the machine stays idle.
- R4: The steps run in this order: 0 clock switch, 1 counter increment, 2 counter write, 3 legality check, 4 hash, 5 erase, 6 low-half compare, 7 high-half compare, 8 state write. Step k waits until step_done_i[k]. step_start_o[k] is high only in the first cycle of step k.
- R5: In steps 1, 2, 3, 4, 6, 7 and 8, step_err_i[k] leads to post and sets trans_fail_o. An error wins over a done that arrives in the same cycle.
- R6: step_err_i[0] and step_err_i[5] have no effect: the machine keeps waiting in that step.
- R7: A done in step 6 while tok_lo_ok_i is low, or in step 7 while tok_hi_ok_i is low, leads to post and sets tok_err_o and trans_fail_o. A done in step 8 leads to post and sets trans_ok_o. All flags are sticky until reset.
- R8: If alarm_a_i or alarm_b_i is high in idle, any step, post, fault or alarm, the next state is alarm. This overrides every other condition and sets no flag.
- R9: Post, scrap and alarm are left only by reset. Scrap ignores the alarm inputs.
- R10: A register value that is none of the fifteen codes leads to fault on the next clock. Fault stays put unless an alarm arrives.
- R11: With ERASE_EN=0, a done in step 4 goes straight to step 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_req_i | input | 1 | Transition request, sampled in idle |
| scrap_mode_i | input | 1 | Present lifecycle state is a scrap-type state |
| alarm_a_i | input | 1 | First escalation line |
| alarm_b_i | input | 1 | Second escalation line |
| step_done_i | input | 9 | Per-step completion, bit k for step k |
| step_err_i | input | 9 | Per-step failure, bit k for step k |
| tok_lo_ok_i | input | 1 | Low token half matched |
| tok_hi_ok_i | input | 1 | High token half matched |
| step_start_o | output | 9 | One-cycle start strobe, bit k for step k |
| state_o | output | 7 | Current state code |
| trans_ok_o | output | 1 | Transition completed |
| trans_fail_o | output | 1 | Transition aborted |
| tok_err_o | output | 1 | Token comparison failed |

## Verification
The main instance is built with ERASE_EN=1, so the full nine-step chain is walked. That instance is used for the success path, for an abort at every step that can fail and for an alarm injected in every state that reacts to one. A second instance with ERASE_EN=0 shares the same inputs and is used to show that the hash step skips the erase handshake. Fault codes are placed in the state register from the bench, one all-zero value and one single-bit corruption of a legal code, to show the recovery into the fault state.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
   localparam int IDX_W  = 4;
   localparam int CODE_W = IDX_W + 3;
   localparam int NSTEP  = 9;
   localparam int NSTATE = 15;

   typedef logic [CODE_W-1:0] code_t;

   // Hamming(7,4) codeword of a state index; any two differ in three bits or more
   function automatic code_t enc(input int unsigned idx);
      logic [IDX_W-1:0] d;
      d = idx[IDX_W-1:0];
      return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
   endfunction

   function automatic int min_dist();
      int best;
      best = CODE_W;
      for (int i = 1; i <= NSTATE; i++) begin
         for (int j = i + 1; j <= NSTATE; j++) begin
            code_t x;
            int    n;
            x = enc(i) ^ enc(j);
            n = 0;
            for (int b = 0; b < CODE_W; b++) n += int'(x[b]);
            if (n < best) best = n;
         end
      end
      return best;
   endfunction

   localparam code_t S_BOOT     = enc(1);
   localparam code_t S_IDLE     = enc(2);
   localparam code_t S_CLKSW    = enc(3);
   localparam code_t S_CTR_INC  = enc(4);
   localparam code_t S_CTR_WR   = enc(5);
   localparam code_t S_LEGAL    = enc(6);
   localparam code_t S_HASH     = enc(7);
   localparam code_t S_ERASE    = enc(8);
   localparam code_t S_CMP_LO   = enc(9);
   localparam code_t S_CMP_HI   = enc(10);
   localparam code_t S_STATE_WR = enc(11);
   localparam code_t S_POST     = enc(12);
   localparam code_t S_SCRAP    = enc(13);
   localparam code_t S_ALARM    = enc(14);
   localparam code_t S_BAD      = enc(15);
endpackage

// File: rtl/lseq_next.sv
module lseq_next
   import lseq_pkg::*;
#(
   parameter int ERASE_EN = 1
) (
   input  code_t            cur_i,
   input  logic             req_i,
   input  logic             scrap_i,
   input  logic             esc_i,
   input  logic [NSTEP-1:0] done_i,
   input  logic [NSTEP-1:0] err_i,
   input  logic             lo_ok_i,
   input  logic             hi_ok_i,
   output code_t            nxt_o,
   output logic             ok_set_o,
   output logic             fail_set_o,
   output logic             tok_set_o
);
   code_t after_hash;
   logic  unused_err;

   assign unused_err = err_i[0] ^ err_i[5];

   generate
      if (ERASE_EN != 0) begin : g_erase
         assign after_hash = S_ERASE;
      end else begin : g_no_erase
         assign after_hash = S_CMP_LO;
      end
   endgenerate

   always_comb begin
      logic legal;
      code_t n;
      logic  ok, fail, tok;
      n     = cur_i;
      ok    = 1'b0;
      fail  = 1'b0;
      tok   = 1'b0;
      legal = 1'b1;
      case (cur_i)
         S_BOOT: n = S_IDLE;
         S_IDLE: begin
            if (scrap_i)    n = S_SCRAP;
            else if (req_i) n = S_CLKSW;
         end
         S_CLKSW: if (done_i[0]) n = S_CTR_INC;
         S_CTR_INC: begin
            if (err_i[1])       begin n = S_POST; fail = 1'b1; end
            else if (done_i[1]) n = S_CTR_WR;
         end
         S_CTR_WR: begin
            if (err_i[2])       begin n = S_POST; fail = 1'b1; end
            else if (done_i[2]) n = S_LEGAL;
         end
         S_LEGAL: begin
            if (err_i[3])       begin n = S_POST; fail = 1'b1; end
            else if (done_i[3]) n = S_HASH;
         end
         S_HASH: begin
            if (err_i[4])       begin n = S_POST; fail = 1'b1; end
            else if (done_i[4]) n = after_hash;
         end
         S_ERASE: if (done_i[5]) n = S_CMP_LO;
         S_CMP_LO: begin
            if (err_i[6]) begin n = S_POST; fail = 1'b1; end
            else if (done_i[6]) begin
               if (lo_ok_i) n = S_CMP_HI;
               else begin n = S_POST; fail = 1'b1; tok = 1'b1; end
            end
         end
         S_CMP_HI: begin
            if (err_i[7]) begin n = S_POST; fail = 1'b1; end
            else if (done_i[7]) begin
               if (hi_ok_i) n = S_STATE_WR;
               else begin n = S_POST; fail = 1'b1; tok = 1'b1; end
            end
         end
         S_STATE_WR: begin
            if (err_i[8])       begin n = S_POST; fail = 1'b1; end
            else if (done_i[8]) begin n = S_POST; ok = 1'b1; end
         end
         S_POST, S_SCRAP, S_ALARM, S_BAD: n = cur_i;
         default: begin
            n     = S_BAD;
            legal = 1'b0;
         end
      endcase
      // escalation overrides every other outcome
      if (esc_i && legal && cur_i != S_BOOT && cur_i != S_SCRAP) begin
         n    = S_ALARM;
         ok   = 1'b0;
         fail = 1'b0;
         tok  = 1'b0;
      end
      nxt_o      = n;
      ok_set_o   = ok;
      fail_set_o = fail;
      tok_set_o  = tok;
   end
endmodule

// File: rtl/lseq_state_reg.sv
module lseq_state_reg
   import lseq_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  code_t nxt_i,
   output code_t state_o,
   output logic  fresh_o
);
   code_t state_q;
   logic  fresh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= S_BOOT;
         fresh_q <= 1'b0;
      end else begin
         state_q <= nxt_i;
         fresh_q <= (nxt_i != state_q);
      end
   end

   assign state_o = state_q;
   assign fresh_o = fresh_q;
endmodule

// File: rtl/lseq_flags.sv
module lseq_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ok_set_i,
   input  logic fail_set_i,
   input  logic tok_set_i,
   output logic ok_o,
   output logic fail_o,
   output logic tok_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ok_o   <= 1'b0;
         fail_o <= 1'b0;
         tok_o  <= 1'b0;
      end else begin
         ok_o   <= ok_o | ok_set_i;
         fail_o <= fail_o | fail_set_i;
         tok_o  <= tok_o | tok_set_i;
      end
   end
endmodule

// File: rtl/lseq_fsm.sv
module lseq_fsm
   import lseq_pkg::*;
#(
   parameter int ERASE_EN = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             xfer_req_i,
   input  logic             scrap_mode_i,
   input  logic             alarm_a_i,
   input  logic             alarm_b_i,
   input  logic [NSTEP-1:0] step_done_i,
   input  logic [NSTEP-1:0] step_err_i,
   input  logic             tok_lo_ok_i,
   input  logic             tok_hi_ok_i,
   output logic [NSTEP-1:0] step_start_o,
   output logic [CODE_W-1:0] state_o,
   output logic             trans_ok_o,
   output logic             trans_fail_o,
   output logic             tok_err_o
);
   localparam int DIST = min_dist();

   if (ERASE_EN != 0 && ERASE_EN != 1) begin : g_chk_erase
      $error("ERASE_EN must be 0 or 1");
   end
   if (DIST < 3) begin : g_chk_dist
      $error("state codes too close");
   end

   code_t nxt, cur;
   logic  fresh, ok_set, fail_set, tok_set;

   lseq_next #(.ERASE_EN(ERASE_EN)) u_next (
      .cur_i     (cur),
      .req_i     (xfer_req_i),
      .scrap_i   (scrap_mode_i),
      .esc_i     (alarm_a_i | alarm_b_i),
      .done_i    (step_done_i),
      .err_i     (step_err_i),
      .lo_ok_i   (tok_lo_ok_i),
      .hi_ok_i   (tok_hi_ok_i),
      .nxt_o     (nxt),
      .ok_set_o  (ok_set),
      .fail_set_o(fail_set),
      .tok_set_o (tok_set)
   );

   lseq_state_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .nxt_i  (nxt),
      .state_o(cur),
      .fresh_o(fresh)
   );

   lseq_flags u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ok_set_i  (ok_set),
      .fail_set_i(fail_set),
      .tok_set_i (tok_set),
      .ok_o      (trans_ok_o),
      .fail_o    (trans_fail_o),
      .tok_o     (tok_err_o)
   );

   for (genvar k = 0; k < NSTEP; k++) begin : g_strobe
      assign step_start_o[k] = fresh && (cur == enc(k + 3));
   end

   assign state_o = cur;
endmodule

// File: rtl/lseq_fsm_chk.sv
module lseq_fsm_chk
   import lseq_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             alarm_a_i,
   input logic             alarm_b_i,
   input logic [NSTEP-1:0] step_start_o,
   input logic [CODE_W-1:0] state_o,
   input logic             trans_ok_o,
   input logic             trans_fail_o,
   input logic             tok_err_o
);
   logic legal, esc;
   assign esc   = alarm_a_i | alarm_b_i;
   assign legal = state_o inside {S_BOOT, S_IDLE, S_CLKSW, S_CTR_INC, S_CTR_WR, S_LEGAL,
                                  S_HASH, S_ERASE, S_CMP_LO, S_CMP_HI, S_STATE_WR,
                                  S_POST, S_SCRAP, S_ALARM, S_BAD};

   p_boot_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == S_BOOT |=> state_o == S_IDLE);

   p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(step_start_o));

   p_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(trans_ok_o && trans_fail_o));

   p_tok_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tok_err_o |=> tok_err_o && trans_fail_o);

   p_escalate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      esc && legal && state_o != S_BOOT && state_o != S_SCRAP |=> state_o == S_ALARM);

   p_scrap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == S_SCRAP |=> state_o == S_SCRAP);

   p_post_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_o == S_POST && !esc |=> state_o == S_POST);

   p_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !legal |=> state_o == S_BAD);
endmodule

bind lseq_fsm lseq_fsm_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .alarm_a_i   (alarm_a_i),
   .alarm_b_i   (alarm_b_i),
   .step_start_o(step_start_o),
   .state_o     (state_o),
   .trans_ok_o  (trans_ok_o),
   .trans_fail_o(trans_fail_o),
   .tok_err_o   (tok_err_o)
);

// File: tb/tb_lseq_fsm.sv
`timescale 1ns/1ps
module tb_lseq_fsm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 0, scrap = 0, al_a = 0, al_b = 0, lo_ok = 1, hi_ok = 1;
   logic [8:0] done_v = '0, err_v = '0;
   logic [8:0] start;
   logic [6:0] st;
   logic       f_ok, f_fail, f_tok;
   logic [8:0] ne_start;
   logic [6:0] ne_st;
   logic       ne_ok, ne_fail, ne_tok;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    cmp_en = 0;

   always #5 clk = ~clk;

   lseq_fsm #(.ERASE_EN(1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .xfer_req_i(req), .scrap_mode_i(scrap),
      .alarm_a_i(al_a), .alarm_b_i(al_b), .step_done_i(done_v), .step_err_i(err_v),
      .tok_lo_ok_i(lo_ok), .tok_hi_ok_i(hi_ok), .step_start_o(start), .state_o(st),
      .trans_ok_o(f_ok), .trans_fail_o(f_fail), .tok_err_o(f_tok));

   lseq_fsm #(.ERASE_EN(0)) dut_ne (
      .clk_i(clk), .rst_ni(rst_n), .xfer_req_i(req), .scrap_mode_i(scrap),
      .alarm_a_i(al_a), .alarm_b_i(al_b), .step_done_i(done_v), .step_err_i(err_v),
      .tok_lo_ok_i(lo_ok), .tok_hi_ok_i(hi_ok), .step_start_o(ne_start), .state_o(ne_st),
      .trans_ok_o(ne_ok), .trans_fail_o(ne_fail), .tok_err_o(ne_tok));

   // state code as written in R1
   function automatic logic [6:0] benc(input int i);
      logic [3:0] d;
      d = i[3:0];
      return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
   endfunction

   function automatic int bidx(input logic [6:0] c);
      for (int i = 1; i <= 15; i++) if (benc(i) == c) return i;
      return 0;
   endfunction

   // reference model: next index from the requirements
   logic [6:0] m_code;
   bit         m_fresh, m_ok, m_fail, m_tok;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_code <= benc(1); m_fresh <= 0; m_ok <= 0; m_fail <= 0; m_tok <= 0;
      end else begin
         int idx, ni, k;
         bit sok, sfail, stok;
         idx = bidx(m_code);
         ni = idx; sok = 0; sfail = 0; stok = 0;
         if (idx == 0) ni = 15;
         else if ((al_a || al_b) && idx != 1 && idx != 13) ni = 14;
         else if (idx == 1) ni = 2;
         else if (idx == 2) begin
            if (scrap) ni = 13; else if (req) ni = 3;
         end else if (idx >= 3 && idx <= 11) begin
            k = idx - 3;
            if (err_v[k] && k != 0 && k != 5) begin ni = 12; sfail = 1; end
            else if (done_v[k]) begin
               if (k == 6 && !lo_ok) begin ni = 12; sfail = 1; stok = 1; end
               else if (k == 7 && !hi_ok) begin ni = 12; sfail = 1; stok = 1; end
               else if (k == 8) begin ni = 12; sok = 1; end
               else ni = idx + 1;
            end
         end
         m_fresh <= (benc(ni) != m_code);
         m_code  <= benc(ni);
         m_ok    <= m_ok | sok;
         m_fail  <= m_fail | sfail;
         m_tok   <= m_tok | stok;
      end
   end

   task automatic chk(input bit good, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         int mi;
         logic [8:0] es;
         mi = bidx(m_code);
         es = (m_fresh && mi >= 3 && mi <= 11) ? 9'(1 << (mi - 3)) : 9'd0;
         chk(st == m_code, cur_req, 32'(st), 32'(m_code));
         chk(start == es, cur_req, 32'(start), 32'(es));
         chk({f_ok, f_fail, f_tok} == {m_ok, m_fail, m_tok}, cur_req,
             32'({f_ok, f_fail, f_tok}), 32'({m_ok, m_fail, m_tok}));
      end
   end

   task automatic cyc(); @(negedge clk); #1; endtask

   task automatic reset_dut();
      cyc();
      rst_n = 0; req = 0; scrap = 0; al_a = 0; al_b = 0;
      done_v = '0; err_v = '0; lo_ok = 1; hi_ok = 1;
      cyc();
      rst_n = 1;
   endtask

   task automatic wait_code(input int idx);
      for (int i = 0; i < 60; i++) begin
         if (st == benc(idx)) break;
         @(negedge clk);
      end
   endtask

   task automatic give(input int k, input int dly, input bit e, input bit d);
      wait_code(k + 3);
      repeat (dly) @(negedge clk);
      #1;
      err_v[k] = e; done_v[k] = d;
      cyc();
      err_v[k] = 0; done_v[k] = 0;
   endtask

   task automatic kick();
      wait_code(2);
      #1; req = 1;
      cyc();
      req = 0;
   endtask

   task automatic walk(input int upto);
      kick();
      for (int k = 0; k < upto; k++) give(k, k % 3, 0, 1);
   endtask

   task automatic alarm(input bit sel, input string r);
      #1;
      if (sel) al_b = 1; else al_a = 1;
      cyc();
      al_a = 0; al_b = 0;
      chk(st == benc(14), r, 32'(st), 32'(benc(14)));
   endtask

   // place a code outside the fifteen in the state register (fault injection)
   task automatic inject(input bit flip);
      cyc();
      if (flip) force dut.u_reg.state_q = 7'h55;
      else      force dut.u_reg.state_q = 7'h00;
      m_code = flip ? 7'h55 : 7'h00;
      #1;
      release dut.u_reg.state_q;
      cyc();
      chk(st == benc(15), "R10", 32'(st), 32'(benc(15)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R4 watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      cyc(); cyc();
      chk(st == benc(1) && st == 7'h0B, "R1", 32'(st), 32'h0B);
      chk({start, f_ok, f_fail, f_tok} == '0, "R1", 32'({start, f_ok, f_fail, f_tok}), 0);
      cmp_en = 1;
      // R2: boot ignores the alarm lines
      cur_req = "R2";
      rst_n = 1; al_a = 1;
      cyc();
      al_a = 0;
      chk(st == benc(2), "R2", 32'(st), 32'(benc(2)));
      cyc();
      chk(st == benc(2), "R2", 32'(st), 32'(benc(2)));

      // R3: idle holds, scrap wins over request
      cur_req = "R3";
      repeat (3) cyc();
      chk(st == benc(2), "R3", 32'(st), 32'(benc(2)));
      scrap = 1; req = 1;
      cyc();
      scrap = 0; req = 0;
      chk(st == benc(13), "R3", 32'(st), 32'(benc(13)));
      // R9: scrap ignores alarms and requests
      cur_req = "R9";
      al_a = 1; al_b = 1; req = 1;
      cyc(); cyc();
      al_a = 0; al_b = 0; req = 0;
      chk(st == benc(13), "R9", 32'(st), 32'(benc(13)));

      // R4, R7: full successful transition
      cur_req = "R4";
      reset_dut();
      walk(9);
      cyc();
      chk(st == benc(12) && f_ok && !f_fail, "R7", 32'({st, f_ok, f_fail}), 32'({benc(12), 2'b10}));
      // R9: post is terminal
      cur_req = "R9";
      req = 1; done_v = '1; err_v = '1;
      cyc(); cyc();
      req = 0; done_v = '0; err_v = '0;
      chk(st == benc(12), "R9", 32'(st), 32'(benc(12)));

      // R5: abort at every step that can fail, error beating done
      cur_req = "R5";
      for (int k = 1; k <= 8; k++) begin
         if (k != 5) begin
            reset_dut();
            walk(k);
            give(k, 1, 1, 1);
            chk(st == benc(12) && f_fail && !f_tok && !f_ok, "R5",
                32'({st, f_fail, f_tok}), 32'({benc(12), 2'b10}));
         end
      end

      // R6: errors in the clock-switch and erase steps are ignored
      cur_req = "R6";
      reset_dut();
      kick();
      wait_code(3);
      #1; err_v[0] = 1;
      cyc(); cyc();
      err_v[0] = 0;
      chk(st == benc(3) && !f_fail, "R6", 32'(st), 32'(benc(3)));
      give(0, 0, 0, 1);
      for (int k = 1; k < 5; k++) give(k, 0, 0, 1);
      wait_code(8);
      #1; err_v[5] = 1;
      cyc(); cyc();
      err_v[5] = 0;
      chk(st == benc(8) && !f_fail, "R6", 32'(st), 32'(benc(8)));

      // R7: token mismatch in either half
      cur_req = "R7";
      reset_dut();
      lo_ok = 0;
      walk(6);
      give(6, 0, 0, 1);
      chk(st == benc(12) && f_tok && f_fail, "R7", 32'({st, f_tok}), 32'({benc(12), 1'b1}));
      reset_dut();
      hi_ok = 0;
      walk(7);
      give(7, 2, 0, 1);
      chk(st == benc(12) && f_tok && f_fail, "R7", 32'({st, f_tok}), 32'({benc(12), 1'b1}));

      // R8: alarm in idle, every step and post; alarm stays (R9)
      cur_req = "R8";
      for (int s = 2; s <= 12; s++) begin
         reset_dut();
         if (s == 2) wait_code(2);
         else if (s <= 11) begin walk(s - 3); wait_code(s); end
         else begin walk(9); wait_code(12); end
         alarm(s[0], "R8");
         req = 1; scrap = 1;
         cyc();
         req = 0; scrap = 0;
         chk(st == benc(14), "R9", 32'(st), 32'(benc(14)));
      end

      // R10: fault codes, then alarm from fault
      cur_req = "R10";
      reset_dut();
      wait_code(2);
      inject(0);
      cyc(); cyc();
      chk(st == benc(15), "R10", 32'(st), 32'(benc(15)));
      cur_req = "R8";
      alarm(1, "R8");
      cur_req = "R10";
      reset_dut();
      walk(2);
      wait_code(5);
      inject(1);

      // R11: the variant without erase goes from hash to low compare
      cur_req = "R11";
      reset_dut();
      walk(4);
      give(4, 0, 0, 1);
      chk(ne_st == benc(9), "R11", 32'(ne_st), 32'(benc(9)));
      chk(st == benc(8), "R11", 32'(st), 32'(benc(8)));

      cyc();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule